// File: doc/BRIEF.md
# Flash erase and program sequencer

This block is the host-side engine that rewrites a byte-wide parallel flash device in one job. After a start pulse it erases the device one block at a time, starting at address zero and moving up by the configured block size until the configured total size is reached. It reads back every erased block and requires all bytes to be 0xFF. It then programs every byte in ascending address order, taking the data from a source port. Every erase and every byte program is a short command script followed by a status-polling loop and a return to array mode.

The flash bus is a registered master. A write is a one-cycle `fl_we` strobe with `fl_addr` and `fl_wdata`. A read is a one-cycle `fl_re` strobe, and the device presents `fl_rdata` one clock later. The source port behaves the same way: `src_req` with `src_addr`, then `src_data` is valid one clock later. The job ends with a one-cycle `done` pulse or a one-cycle `err` pulse, with a reason code on `err_code`. `cfg_block` must be nonzero, and `cfg_total` must be a nonzero multiple of it.

Top module: `flash_job_seq`

## Requirements
- R1: Each block erase writes 0x50, then 0x20, then 0xD0, all at the block base address. Block bases run 0, B, 2B, … up to T−B, where T is `cfg_total` and B is `cfg_block`, both latched at start.
- R2: After the write that starts an operation (0xD0 for an erase, the data byte for a program), exactly PRE_POLL_CYCLES idle cycles pass. The block then writes 0x70 at the operation address and reads status repeatedly until bit 7 of the returned byte is 1.
- R3: Once status is captured, or the poll limit is reached, the next bus write is 0xFF at the operation address, and it is the last write of that operation.
- R4: After each erase, every byte of the block is read. Any value other than 0xFF ends the job with code 5, and no further erase or program command is issued.
- R5: Programming starts only after all blocks are erased and verified. Each address 0…T−1, in ascending order, gets 0x40 followed by the byte that the source port returned for that address.
- R6: A captured status with bit 5 set ends the job with code 1. Otherwise bit 4 gives code 2, bit 3 gives code 3, and bit 1 gives code 4. Bits 6, 2 and 0 have no effect.
- R7: If TIMEOUT_POLLS status reads in a row all show bit 7 as 0, the job ends with code 6.
- R8: Success gives a single-cycle `done` pulse with `err_code` 0. Failure gives a single-cycle `err` pulse with a nonzero `err_code`. Never both in the same job.
- R9: A start pulse while `busy` is high is ignored. The running job keeps its latched configuration, and no second job follows.
- R10: After reset, `busy`, `done`, `err`, `err_code` and all bus and source strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when idle |
| cfg_total | input | ADDR_W+1 | Device size in bytes |
| cfg_block | input | ADDR_W+1 | Erase block size in bytes |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on failure |
| err_code | output | 3 | Failure reason (1 to 6), 0 on success |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read byte, valid one cycle after `fl_re` |
| src_req | output | 1 | Source byte request |
| src_addr | output | ADDR_W | Source byte address |
| src_data | input | 8 | Source byte, valid one cycle after `src_req` |

## Verification
The bench builds the block with ADDR_W=6, PRE_POLL_CYCLES=2 and TIMEOUT_POLLS=8, against a behavioural 64-byte flash model. With these values every job rewrites the whole array byte by byte. Each job is short, so block sizes from 8 to 64 can be swept, and the full write trace of every job can be compared entry by entry with a trace computed arithmetically. The small poll limit puts the timeout path within a few dozen cycles. Error bits are injected at both erase and program operations, and a stuck byte is planted in chosen blocks to exercise verify failure.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam logic [7:0] C_CLR_STATUS = 8'h50;
  localparam logic [7:0] C_ERASE_SET  = 8'h20;
  localparam logic [7:0] C_CONFIRM    = 8'hD0;
  localparam logic [7:0] C_STATUS     = 8'h70;
  localparam logic [7:0] C_ARRAY      = 8'hFF;
  localparam logic [7:0] C_PROG_SET   = 8'h40;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_ERASE   = 3'd1,
    E_PROG    = 3'd2,
    E_VOLT    = 3'd3,
    E_LOCK    = 3'd4,
    E_VERIFY  = 3'd5,
    E_TIMEOUT = 3'd6
  } fseq_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ER_SETUP,
    S_ER_CONF,
    S_DELAY,
    S_POLL_ISSUE,
    S_POLL_WAIT,
    S_POLL_EVAL,
    S_AFTER,
    S_VER_WAIT,
    S_VER_EVAL,
    S_FETCH_WAIT,
    S_PG_CMD,
    S_PG_DATA,
    S_FINISH
  } fseq_state_e;

endpackage

// File: rtl/fseq_countdown.sv
module fseq_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/fseq_status_chk.sv
module fseq_status_chk
  import fseq_pkg::*;
(
  input  logic [7:0] stat,
  output logic       ready,
  output fseq_err_e  code
);

  assign ready = stat[7];

  // Highest-priority failure bit wins; suspend flags are don't-care.
  always_comb begin
    casez (stat)
      8'b??1?????: code = E_ERASE;
      8'b???1????: code = E_PROG;
      8'b????1???: code = E_VOLT;
      8'b??????1?: code = E_LOCK;
      default:     code = E_NONE;
    endcase
  end

endmodule

// File: rtl/flash_job_seq.sv
module flash_job_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int PRE_POLL_CYCLES = 4,
  parameter int TIMEOUT_POLLS   = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   cfg_total,
  input  logic [ADDR_W:0]   cfg_block,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [7:0]        src_data
);

  localparam int SZ_W  = ADDR_W + 1;
  localparam int DLY_W = (PRE_POLL_CYCLES < 2) ? 1 : $clog2(PRE_POLL_CYCLES + 1);
  localparam int TO_W  = (TIMEOUT_POLLS < 2) ? 1 : $clog2(TIMEOUT_POLLS + 1);
  localparam logic [SZ_W-1:0]  ONE_A     = SZ_W'(1);
  localparam logic [DLY_W-1:0] DLY_LOAD  = DLY_W'(PRE_POLL_CYCLES);
  localparam logic [TO_W-1:0]  POLL_LOAD = TO_W'(TIMEOUT_POLLS - 1);

  fseq_state_e     state_q;
  logic [SZ_W-1:0] tot_q, blk_q, base_q, vptr_q, paddr_q;
  logic            op_prog_q;
  logic [7:0]      data_q;
  fseq_err_e       code_q;

  logic [SZ_W-1:0] cur_addr, next_base, blk_last, next_paddr, next_vptr;
  logic            dly_load, dly_dec, dly_zero;
  logic            poll_load, poll_dec, poll_zero;
  logic            st_ready;
  fseq_err_e       st_code;

  assign cur_addr   = op_prog_q ? paddr_q : base_q;
  assign next_base  = base_q + blk_q;
  assign blk_last   = next_base - ONE_A;
  assign next_paddr = paddr_q + ONE_A;
  assign next_vptr  = vptr_q + ONE_A;

  assign dly_load  = (state_q == S_ER_CONF) || (state_q == S_PG_DATA);
  assign dly_dec   = (state_q == S_DELAY);
  assign poll_load = (state_q == S_DELAY) && dly_zero;
  assign poll_dec  = (state_q == S_POLL_EVAL) && !st_ready && !poll_zero;

  fseq_countdown #(.W(DLY_W)) u_delay (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(DLY_LOAD),
    .dec(dly_dec), .zero(dly_zero)
  );

  fseq_countdown #(.W(TO_W)) u_poll (
    .clk(clk), .rst(rst), .load(poll_load), .load_val(POLL_LOAD),
    .dec(poll_dec), .zero(poll_zero)
  );

  fseq_status_chk u_stat (
    .stat(fl_rdata), .ready(st_ready), .code(st_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= 3'd0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      fl_we     <= 1'b0;
      fl_re     <= 1'b0;
      src_req   <= 1'b0;
      src_addr  <= '0;
      tot_q     <= '0;
      blk_q     <= '0;
      base_q    <= '0;
      vptr_q    <= '0;
      paddr_q   <= '0;
      op_prog_q <= 1'b0;
      data_q    <= '0;
      code_q    <= E_NONE;
    end else begin
      fl_we   <= 1'b0;
      fl_re   <= 1'b0;
      src_req <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            tot_q     <= cfg_total;
            blk_q     <= cfg_block;
            base_q    <= '0;
            paddr_q   <= '0;
            op_prog_q <= 1'b0;
            code_q    <= E_NONE;
            busy      <= 1'b1;
            fl_we     <= 1'b1;
            fl_addr   <= '0;
            fl_wdata  <= C_CLR_STATUS;
            state_q   <= S_ER_SETUP;
          end
        end
        S_ER_SETUP: begin
          fl_we    <= 1'b1;
          fl_addr  <= base_q[ADDR_W-1:0];
          fl_wdata <= C_ERASE_SET;
          state_q  <= S_ER_CONF;
        end
        S_ER_CONF: begin
          fl_we    <= 1'b1;
          fl_addr  <= base_q[ADDR_W-1:0];
          fl_wdata <= C_CONFIRM;
          state_q  <= S_DELAY;
        end
        S_DELAY: begin
          if (dly_zero) begin
            fl_we    <= 1'b1;
            fl_addr  <= cur_addr[ADDR_W-1:0];
            fl_wdata <= C_STATUS;
            state_q  <= S_POLL_ISSUE;
          end
        end
        S_POLL_ISSUE: begin
          fl_re   <= 1'b1;
          fl_addr <= cur_addr[ADDR_W-1:0];
          state_q <= S_POLL_WAIT;
        end
        S_POLL_WAIT: begin
          state_q <= S_POLL_EVAL;
        end
        S_POLL_EVAL: begin
          if (st_ready || poll_zero) begin
            code_q   <= st_ready ? st_code : E_TIMEOUT;
            fl_we    <= 1'b1;
            fl_addr  <= cur_addr[ADDR_W-1:0];
            fl_wdata <= C_ARRAY;
            state_q  <= S_AFTER;
          end else begin
            fl_re   <= 1'b1;
            fl_addr <= cur_addr[ADDR_W-1:0];
            state_q <= S_POLL_WAIT;
          end
        end
        S_AFTER: begin
          if (code_q != E_NONE) begin
            state_q <= S_FINISH;
          end else if (!op_prog_q) begin
            vptr_q  <= base_q;
            fl_re   <= 1'b1;
            fl_addr <= base_q[ADDR_W-1:0];
            state_q <= S_VER_WAIT;
          end else if (next_paddr == tot_q) begin
            state_q <= S_FINISH;
          end else begin
            paddr_q  <= next_paddr;
            src_req  <= 1'b1;
            src_addr <= next_paddr[ADDR_W-1:0];
            state_q  <= S_FETCH_WAIT;
          end
        end
        S_VER_WAIT: begin
          state_q <= S_VER_EVAL;
        end
        S_VER_EVAL: begin
          if (fl_rdata != ERASED_BYTE) begin
            code_q  <= E_VERIFY;
            state_q <= S_FINISH;
          end else if (vptr_q == blk_last) begin
            if (next_base == tot_q) begin
              op_prog_q <= 1'b1;
              paddr_q   <= '0;
              src_req   <= 1'b1;
              src_addr  <= '0;
              state_q   <= S_FETCH_WAIT;
            end else begin
              base_q   <= next_base;
              fl_we    <= 1'b1;
              fl_addr  <= next_base[ADDR_W-1:0];
              fl_wdata <= C_CLR_STATUS;
              state_q  <= S_ER_SETUP;
            end
          end else begin
            vptr_q  <= next_vptr;
            fl_re   <= 1'b1;
            fl_addr <= next_vptr[ADDR_W-1:0];
            state_q <= S_VER_WAIT;
          end
        end
        S_FETCH_WAIT: begin
          state_q <= S_PG_CMD;
        end
        S_PG_CMD: begin
          data_q   <= src_data;
          fl_we    <= 1'b1;
          fl_addr  <= paddr_q[ADDR_W-1:0];
          fl_wdata <= C_PROG_SET;
          state_q  <= S_PG_DATA;
        end
        S_PG_DATA: begin
          fl_we    <= 1'b1;
          fl_addr  <= paddr_q[ADDR_W-1:0];
          fl_wdata <= data_q;
          state_q  <= S_DELAY;
        end
        S_FINISH: begin
          busy     <= 1'b0;
          done     <= (code_q == E_NONE);
          err      <= (code_q != E_NONE);
          err_code <= code_q;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [2:0] err_code,
  input logic       fl_we,
  input logic       fl_re,
  input logic       src_req
);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_end_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> $past(busy));

  p_err_code_set_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 3'd0));

  p_done_code_zero_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code == 3'd0));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(fl_we || fl_re || src_req));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_we, fl_re, src_req}));

endmodule

bind flash_job_seq fseq_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .err_code(err_code), .fl_we(fl_we), .fl_re(fl_re), .src_req(src_req)
);

// File: tb/sim_flash_job_seq.sv
module sim_flash_job_seq;

  localparam int AW  = 6;
  localparam int MEM = 64;
  localparam int PRE = 2;
  localparam int TOP = 8;
  localparam int ER_BUSY = 9;
  localparam int PG_BUSY = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW:0]   cfg_total = '0;
  logic [AW:0]   cfg_block = '0;
  logic          busy, done, err;
  logic [2:0]    err_code;
  logic [AW-1:0] fl_addr, src_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we, fl_re, src_req;
  logic [7:0]    fl_rdata = '0;
  logic [7:0]    src_data = '0;

  flash_job_seq #(.ADDR_W(AW), .PRE_POLL_CYCLES(PRE), .TIMEOUT_POLLS(TOP)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_total(cfg_total), .cfg_block(cfg_block),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .src_req(src_req), .src_addr(src_addr), .src_data(src_data)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // model configuration, written only by the stimulus process
  int m_block = 16, m_stuck = -1, m_inj_op = -1, m_hang_op = -1, m_seed = 0;
  logic [6:0] m_inj_bits = '0;

  // behavioural flash device
  logic [7:0] mem [MEM];
  int   mode, busy_cnt, op_idx;
  logic pend;
  logic [6:0] errs;

  always @(posedge clk) begin
    if (rst) begin
      mode <= 0; busy_cnt <= 0; op_idx <= 0; pend <= 1'b0; errs <= '0;
      for (int i = 0; i < MEM; i++) mem[i] <= 8'(i ^ 8'h5A ^ m_seed);
    end else begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (fl_we) begin
        if (mode == 2) begin
          mem[fl_addr] <= fl_wdata;
          busy_cnt <= (op_idx == m_hang_op) ? 1000000 : PG_BUSY;
          if (op_idx == m_inj_op) errs <= errs | m_inj_bits;
          op_idx <= op_idx + 1;
          mode <= 1;
        end else begin
          case (fl_wdata)
            8'h50: errs <= '0;
            8'h20: pend <= 1'b1;
            8'hD0: if (pend) begin
              for (int i = 0; i < MEM; i++)
                if ((i / m_block) == (int'(fl_addr) / m_block))
                  mem[i] <= (i == m_stuck) ? 8'h00 : 8'hFF;
              busy_cnt <= (op_idx == m_hang_op) ? 1000000 : ER_BUSY;
              if (op_idx == m_inj_op) errs <= errs | m_inj_bits;
              op_idx <= op_idx + 1;
              pend <= 1'b0;
              mode <= 1;
            end
            8'h70: mode <= 1;
            8'hFF: begin mode <= 0; pend <= 1'b0; end
            8'h40: mode <= 2;
            default: ;
          endcase
        end
      end
      if (fl_re) fl_rdata <= (mode == 1) ? {busy_cnt == 0, errs} : mem[fl_addr];
    end
  end

  always @(posedge clk) if (src_req) src_data <= pat(int'(src_addr));

  // monitor, sampled away from the active edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_a [1024];
  int log_d [1024];
  int log_c [1024];
  int nlog, rd_cnt, n_done, n_err, last_code;

  always @(negedge clk) begin
    if (rst) begin
      nlog = 0; rd_cnt = 0; n_done = 0; n_err = 0; last_code = -1;
    end else begin
      if (fl_we && nlog < 1024) begin
        log_a[nlog] = int'(fl_addr); log_d[nlog] = int'(fl_wdata); log_c[nlog] = cyc;
        nlog++;
      end
      if (fl_re) rd_cnt++;
      if (done) begin n_done++; last_code = int'(err_code); end
      if (err)  begin n_err++;  last_code = int'(err_code); end
    end
  end

  int nchk = 0, nerr = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int ex_a [512];
  int ex_d [512];
  int ex_k [512];
  int ex_n;

  task automatic build_trace(int tot, int blk);
    ex_n = 0;
    for (int b = 0; b < tot; b += blk) begin
      ex_a[ex_n] = b; ex_d[ex_n] = 'h50; ex_k[ex_n] = 1; ex_n++;
      ex_a[ex_n] = b; ex_d[ex_n] = 'h20; ex_k[ex_n] = 1; ex_n++;
      ex_a[ex_n] = b; ex_d[ex_n] = 'hD0; ex_k[ex_n] = 1; ex_n++;
      ex_a[ex_n] = b; ex_d[ex_n] = 'h70; ex_k[ex_n] = 2; ex_n++;
      ex_a[ex_n] = b; ex_d[ex_n] = 'hFF; ex_k[ex_n] = 3; ex_n++;
    end
    for (int a = 0; a < tot; a++) begin
      ex_a[ex_n] = a; ex_d[ex_n] = 'h40;        ex_k[ex_n] = 5; ex_n++;
      ex_a[ex_n] = a; ex_d[ex_n] = int'(pat(a)); ex_k[ex_n] = 5; ex_n++;
      ex_a[ex_n] = a; ex_d[ex_n] = 'h70;        ex_k[ex_n] = 2; ex_n++;
      ex_a[ex_n] = a; ex_d[ex_n] = 'hFF;        ex_k[ex_n] = 3; ex_n++;
    end
  endtask

  // compares the first exp_len expected writes with the observed trace
  task automatic cmp_trace(int exp_len, string len_req);
    int m1 = 0, m2 = 0, m3 = 0, m5 = 0, lim;
    lim = (nlog < exp_len) ? nlog : exp_len;
    for (int i = 0; i < lim; i++) begin
      bit bad;
      bad = (log_a[i] != ex_a[i]) || (log_d[i] != ex_d[i]);
      if (ex_d[i] == 'h70 && i > 0 && (log_c[i] - log_c[i-1]) != PRE + 1) m2++;
      if (bad) begin
        case (ex_k[i])
          1: m1++;
          2: m2++;
          3: m3++;
          default: m5++;
        endcase
      end
    end
    check(m1 == 0, "R1", "erase script mismatches", m1, 0);
    check(m2 == 0, "R2", "status command or gap mismatches", m2, 0);
    check(m3 == 0, "R3", "array-mode write mismatches", m3, 0);
    check(m5 == 0, "R5", "program write mismatches", m5, 0);
    check(nlog == exp_len, len_req, "bus write count", nlog, exp_len);
  endtask

  task automatic run_job(int tot, int blk, int iop, logic [6:0] ibits, int hop,
                         int stk, int seed, bit poke);
    int waited = 0;
    m_block = blk; m_stuck = stk; m_inj_op = iop; m_inj_bits = ibits;
    m_hang_op = hop; m_seed = seed;
    @(negedge clk);
    rst = 1'b1;
    cfg_total = 7'(tot);
    cfg_block = 7'(blk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_done == 0 && n_err == 0 && waited < 40000) begin
      if (poke && waited == 40) begin
        start = 1'b1; cfg_total = 7'(blk); cfg_block = 7'(blk);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    check(waited < 40000, "R8", "job end seen", waited, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic success_job(int tot, int blk, int seed, bit poke);
    int bad_mem = 0;
    run_job(tot, blk, -1, '0, -1, -1, seed, poke);
    build_trace(tot, blk);
    cmp_trace(ex_n, poke ? "R9" : "R5");
    check(n_done == 1, poke ? "R9" : "R8", "done pulses", n_done, 1);
    check(n_err == 0, "R8", "err pulses on good job", n_err, 0);
    check(last_code == 0, "R8", "code on success", last_code, 0);
    for (int a = 0; a < tot; a++) if (mem[a] != pat(a)) bad_mem++;
    check(bad_mem == 0, "R5", "array bytes not equal to source", bad_mem, 0);
    check(!busy, "R8", "busy after job", int'(busy), 0);
  endtask

  task automatic fail_job(int tot, int blk, int iop, logic [6:0] ibits, int hop,
                          int stk, int exp_code, int exp_len, string req);
    run_job(tot, blk, iop, ibits, hop, stk, 3, 1'b0);
    build_trace(tot, blk);
    cmp_trace(exp_len, req);
    check(n_err == 1, req, "err pulses", n_err, 1);
    check(n_done == 0, "R8", "done pulses on failure", n_done, 0);
    check(last_code == exp_code, req, "error code", last_code, exp_code);
  endtask

  function automatic int len_to_op(int tot, int blk, int op);
    int nb = tot / blk;
    return (op < nb) ? 5 * op + 5 : 5 * nb + 4 * (op - nb) + 4;
  endfunction

  initial begin
    // R10: state after reset
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err, "R10", "busy/done/err after reset",
          int'({busy, done, err}), 0);
    check(!fl_we && !fl_re && !src_req, "R10", "strobes after reset",
          int'({fl_we, fl_re, src_req}), 0);
    check(err_code == 3'd0, "R10", "err_code after reset", int'(err_code), 0);

    // R1 R2 R3 R5 R8: geometry sweep
    success_job(64, 16, 1, 1'b0);
    success_job(64, 8, 2, 1'b0);
    success_job(64, 32, 3, 1'b0);
    success_job(64, 64, 4, 1'b0);
    success_job(32, 8, 5, 1'b0);
    success_job(16, 16, 6, 1'b0);

    // R9: start pulse with other configuration during a job
    success_job(64, 16, 7, 1'b1);

    // R6: suspend flags (bits 6 and 2) are not failures
    run_job(64, 16, 2, 7'h44, -1, -1, 8, 1'b0);
    check(n_done == 1 && n_err == 0, "R6", "suspend bits ignored", n_err, 0);

    // R6: each failure bit and the priority order, at erase and program ops
    fail_job(64, 16, 1, 7'h20, -1, -1, 1, len_to_op(64, 16, 1), "R6");
    fail_job(64, 16, 7, 7'h10, -1, -1, 2, len_to_op(64, 16, 7), "R6");
    fail_job(64, 16, 0, 7'h08, -1, -1, 3, len_to_op(64, 16, 0), "R6");
    fail_job(64, 16, 14, 7'h02, -1, -1, 4, len_to_op(64, 16, 14), "R6");
    fail_job(64, 8, 3, 7'h22, -1, -1, 1, len_to_op(64, 8, 3), "R6");
    fail_job(64, 8, 20, 7'h12, -1, -1, 2, len_to_op(64, 8, 20), "R6");
    fail_job(64, 8, 9, 7'h0A, -1, -1, 3, len_to_op(64, 8, 9), "R6");

    // R4: stuck byte in block 1 and in block 0
    fail_job(64, 16, -1, '0, -1, 20, 5, 10, "R4");
    fail_job(64, 8, -1, '0, -1, 0, 5, 5, "R4");
    fail_job(64, 8, -1, '0, -1, 63, 5, 40, "R4");

    // R7: device never ready
    fail_job(64, 16, -1, '0, 0, -1, 6, 5, "R7");
    check(rd_cnt == TOP, "R7", "status reads before timeout", rd_cnt, TOP);
    fail_job(64, 16, -1, '0, 6, -1, 6, len_to_op(64, 16, 6), "R7");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule